// File: doc/BRIEF.md
# Packed Average and Absolute-Difference Vector ALU

This block is a lane-parallel arithmetic unit for a vector datapath. It takes two 128-bit operand vectors, splits them into lanes of 8, 16, 32 or 64 bits, and applies one selected function to every lane at once. The functions are the truncating mean, the rounding mean, the absolute difference, the sum of absolute values, and the minimum or maximum of each lane against a small immediate. Lanes are read as signed or unsigned according to a mode input.

Both means are computed at lane width: each operand is halved and the sum is fixed up with a term taken from the two dropped low bits. This way a lane never needs a carry bit beyond its own width. All lanes are computed in parallel, and the chosen width picks one lane array's output. A parameter selects whether the result is registered. In the default build it is registered, so a result appears one clock after its operands.

Top module: `avgabs_vec_alu`

## Requirements
- R1: With op_sel = 0, each lane yields floor((a+b)/2) of the lane values, read signed when is_signed = 1 and unsigned otherwise, without overflow, as a lane-width value.
- R2: With op_sel = 1, each lane yields floor((a+b+1)/2) of the lane values under the same signedness rule, without overflow.
- R3: With op_sel = 2, each lane yields a-b when a > b and b-a otherwise. The comparison follows is_signed and the difference wraps to the lane width.
- R4: With op_sel = 3, each lane yields |a|+|b| with both operands always read as signed, whatever is_signed says. The sum wraps to the lane width, so the absolute value of the most negative lane value is that value itself.
- R5: With op_sel = 4, each lane yields the smaller of a and k. Here k is imm sign-extended from IMM_W bits to the lane width, and the comparison follows is_signed.
- R6: With op_sel = 5, each lane yields the larger of a and k, with k and the comparison as in R5.
- R7: width_sel 0, 1, 2 and 3 select lanes of 8, 16, 32 and 64 bits, giving 16, 8, 4 and 2 lanes. Lane i occupies bits [i*W +: W], and no lane carries into another.
- R8: op_sel values 6 and 7 drive the whole result to zero.
- R9: The result presented after a rising clock edge is the function of the inputs sampled at that edge, so back-to-back operands give back-to-back results.
- R10: While rst_n is low the result is zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_sel | input | 3 | Function select (see R1 to R8) |
| width_sel | input | 2 | Lane width select (see R7) |
| is_signed | input | 1 | 1 reads lanes as two's complement, 0 as unsigned |
| imm | input | IMM_W | Immediate, sign-extended per lane for min and max |
| vec_a | input | VEC_W | First operand vector |
| vec_b | input | VEC_W | Second operand vector |
| result | output | VEC_W | Lane-wise result |

## Verification
Replicated extreme bytes (all ones, 0x80 against 0x7F, -1 against -2) tell the two mean corrections apart, separate arithmetic from logical halving, and expose where the absolute difference and the absolute sum wrap. An immediate with its top bit set gives opposite min and max answers in signed and unsigned mode, which shows both the sign extension and the compare mode. Carry-heavy patterns at 16, 32 and 64 bits show that lanes stay isolated. A pseudo-random sweep over every op, width and signedness is checked against a widened-arithmetic reference, and unused op codes are shown to return zero.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

   typedef enum logic [2:0] {
      OP_AVG_FLOOR = 3'd0,
      OP_AVG_ROUND = 3'd1,
      OP_ABS_DIFF  = 3'd2,
      OP_ABS_SUM   = 3'd3,
      OP_MIN_K     = 3'd4,
      OP_MAX_K     = 3'd5
   } alu_op_e;

   localparam int NUM_WIDTHS = 4;
   localparam int MIN_LANE_W = 8;
   localparam int MAX_LANE_W = 64;

endpackage

// File: rtl/avgabs_lane.sv
module avgabs_lane
   import simd_avg_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [LANE_W-1:0] k,
   input  alu_op_e           op,
   input  logic              sgn,
   output logic [LANE_W-1:0] y
);
   localparam int MSB = LANE_W - 1;

   if (LANE_W < 2) begin : g_bad_lane
      $error("avgabs_lane: LANE_W must be at least 2");
   end

   // widened copies carry the signedness into one compare structure
   logic signed [LANE_W:0] wa, wb, wk;
   assign wa = {sgn & a[MSB], a};
   assign wb = {sgn & b[MSB], b};
   assign wk = {sgn & k[MSB], k};

   // halved operands: arithmetic shift when signed, logical otherwise
   logic [LANE_W-1:0] ha, hb, half_sum;
   assign ha       = {sgn & a[MSB], a[MSB:1]};
   assign hb       = {sgn & b[MSB], b[MSB:1]};
   assign half_sum = ha + hb;

   logic [LANE_W-1:0] avg_fl, avg_rn;
   assign avg_fl = half_sum + {{MSB{1'b0}}, a[0] & b[0]};
   assign avg_rn = half_sum + {{MSB{1'b0}}, a[0] | b[0]};

   logic              a_gt_b;
   logic [LANE_W-1:0] adiff;
   assign a_gt_b = wa > wb;
   assign adiff  = a_gt_b ? (a - b) : (b - a);

   logic [LANE_W-1:0] mag_a, mag_b, asum;
   assign mag_a = a[MSB] ? ({LANE_W{1'b0}} - a) : a;
   assign mag_b = b[MSB] ? ({LANE_W{1'b0}} - b) : b;
   assign asum  = mag_a + mag_b;

   logic a_lt_k, a_gt_k;
   assign a_lt_k = wa < wk;
   assign a_gt_k = wa > wk;

   always_comb begin
      case (op)
         OP_AVG_FLOOR: y = avg_fl;
         OP_AVG_ROUND: y = avg_rn;
         OP_ABS_DIFF:  y = adiff;
         OP_ABS_SUM:   y = asum;
         OP_MIN_K:     y = a_lt_k ? a : k;
         OP_MAX_K:     y = a_gt_k ? a : k;
         default:      y = '0;
      endcase
   end

endmodule

// File: rtl/avgabs_slice.sv
module avgabs_slice
   import simd_avg_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 8
) (
   input  logic [VEC_W-1:0]  a_vec,
   input  logic [VEC_W-1:0]  b_vec,
   input  logic [LANE_W-1:0] k_lane,
   input  alu_op_e           op,
   input  logic              sgn,
   output logic [VEC_W-1:0]  y_vec
);
   localparam int LANES = VEC_W / LANE_W;

   if (VEC_W % LANE_W != 0) begin : g_bad_split
      $error("avgabs_slice: VEC_W must be a multiple of LANE_W");
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      avgabs_lane #(.LANE_W(LANE_W)) u_lane (
         .a   (a_vec[ln*LANE_W +: LANE_W]),
         .b   (b_vec[ln*LANE_W +: LANE_W]),
         .k   (k_lane),
         .op  (op),
         .sgn (sgn),
         .y   (y_vec[ln*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/avgabs_vec_alu.sv
module avgabs_vec_alu
   import simd_avg_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int IMM_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_sel,
   input  logic [1:0]       width_sel,
   input  logic             is_signed,
   input  logic [IMM_W-1:0] imm,
   input  logic [VEC_W-1:0] vec_a,
   input  logic [VEC_W-1:0] vec_b,
   output logic [VEC_W-1:0] result
);
   localparam int EXT_PAD = MAX_LANE_W - IMM_W;

   if (VEC_W < MAX_LANE_W || (VEC_W % MAX_LANE_W) != 0) begin : g_bad_vec
      $error("avgabs_vec_alu: VEC_W must be a positive multiple of 64");
   end
   if (IMM_W < 2 || IMM_W > 32) begin : g_bad_imm
      $error("avgabs_vec_alu: IMM_W must lie in 2..32");
   end

   logic [MAX_LANE_W-1:0] imm_ext;
   assign imm_ext = {{EXT_PAD{imm[IMM_W-1]}}, imm};

   alu_op_e op_e;
   assign op_e = alu_op_e'(op_sel);

   logic [VEC_W-1:0] slice_y [NUM_WIDTHS];

   for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
      localparam int LW = MIN_LANE_W << g;
      avgabs_slice #(.VEC_W(VEC_W), .LANE_W(LW)) u_slice (
         .a_vec  (vec_a),
         .b_vec  (vec_b),
         .k_lane (imm_ext[LW-1:0]),
         .op     (op_e),
         .sgn    (is_signed),
         .y_vec  (slice_y[g])
      );
   end

   logic [VEC_W-1:0] comb_y;
   assign comb_y = slice_y[width_sel];

   if (REG_OUT) begin : g_reg
      logic [VEC_W-1:0] y_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) y_q <= '0;
         else        y_q <= comb_y;
      end
      assign result = y_q;

      AST_AVG_SELF: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel <= 3'd1 && vec_a == vec_b) |=> result == $past(vec_a)); // R1
      AST_ABSDIFF_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 3'd2 && vec_a == vec_b) |=> result == '0); // R3
      AST_ABSSUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 3'd3 && vec_a == '0 && vec_b == '0) |=> result == '0); // R4
      AST_MINMAX_PICK: assert property (@(posedge clk) disable iff (!rst_n)
         ((op_sel == 3'd4 || op_sel == 3'd5) && width_sel == 2'd3)
         |=> (result[63:0] == $past(vec_a[63:0]) || result[63:0] == $past(imm_ext))); // R5
      AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel >= 3'd6) |=> result == '0); // R8
   end else begin : g_comb
      assign result = comb_y;
   end

endmodule

// File: tb/tb_avgabs_vec_alu.sv
`timescale 1ns/1ps
module tb_avgabs_vec_alu;
   localparam int VW = 128;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_sel = '0;
   logic [1:0]    width_sel = '0;
   logic          is_signed = 1'b0;
   logic [IW-1:0] imm = '0;
   logic [VW-1:0] vec_a = '0;
   logic [VW-1:0] vec_b = '0;
   logic [VW-1:0] result;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [VW-1:0] exp;
      string         tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   avgabs_vec_alu #(.VEC_W(VW), .IMM_W(IW), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .width_sel(width_sel),
      .is_signed(is_signed), .imm(imm), .vec_a(vec_a), .vec_b(vec_b),
      .result(result)
   );

   function automatic logic signed [67:0] tov(logic [63:0] x, int lw, bit sg);
      logic signed [67:0] v;
      v = $signed({4'b0000, x});
      if (sg && x[lw-1]) v = v - (68'sd1 <<< lw);
      return v;
   endfunction

   function automatic logic [VW-1:0] model(logic [2:0] op, logic [1:0] w, bit sg,
                                          logic [IW-1:0] im, logic [VW-1:0] a,
                                          logic [VW-1:0] b);
      logic [VW-1:0] r;
      logic [63:0]   isx;
      int lw, n;
      r   = '0;
      lw  = 8 << w;
      n   = VW / lw;
      isx = {{(64-IW){im[IW-1]}}, im};
      for (int l = 0; l < n; l++) begin
         logic [63:0] xa, xb, xi;
         logic signed [67:0] va, vb, vi, sa, sb2, t;
         xa = '0; xb = '0; xi = '0;
         for (int k = 0; k < lw; k++) begin
            xa[k] = a[l*lw + k];
            xb[k] = b[l*lw + k];
            xi[k] = isx[k];
         end
         va  = tov(xa, lw, sg);
         vb  = tov(xb, lw, sg);
         vi  = tov(xi, lw, sg);
         sa  = tov(xa, lw, 1'b1);
         sb2 = tov(xb, lw, 1'b1);
         case (op)
            3'd0: t = (va + vb) >>> 1;
            3'd1: t = (va + vb + 68'sd1) >>> 1;
            3'd2: t = (va > vb) ? va - vb : vb - va;
            3'd3: t = ((sa < 0) ? -sa : sa) + ((sb2 < 0) ? -sb2 : sb2);
            3'd4: t = (va < vi) ? va : vi;
            3'd5: t = (va > vi) ? va : vi;
            default: t = '0;
         endcase
         for (int k = 0; k < lw; k++) r[l*lw + k] = t[k];
      end
      return r;
   endfunction

   // driver: apply operands at falling edge, queue the expected result
   task automatic drive(logic [2:0] op, logic [1:0] w, bit sg, logic [IW-1:0] im,
                        logic [VW-1:0] a, logic [VW-1:0] b,
                        logic [VW-1:0] exp, string tag);
      item_t it;
      @(negedge clk);
      op_sel = op; width_sel = w; is_signed = sg; imm = im;
      vec_a = a; vec_b = b;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic drive_m(logic [2:0] op, logic [1:0] w, bit sg, logic [IW-1:0] im,
                          logic [VW-1:0] a, logic [VW-1:0] b, string tag);
      drive(op, w, sg, im, a, b, model(op, w, sg, im, a, b), tag);
   endtask

   // monitor: one queued item retires per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (result !== it.exp) begin
               bad++;
               $display("FAIL %s actual=%h expected=%h", it.tag, result, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic string op_tag(logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         default: return "R8";
      endcase
   endfunction

   initial begin
      logic [63:0] lf;
      // R10: reset holds result at zero even with live operands
      vec_a = {16{8'h5A}}; vec_b = {16{8'h33}}; op_sel = 3'd3;
      repeat (3) @(negedge clk);
      total++;
      if (result !== '0) begin
         bad++;
         $display("FAIL R10 actual=%h expected=%h", result, {VW{1'b0}});
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 floor mean
      drive(3'd0, 2'd0, 1'b0, '0, {16{8'hFF}}, {16{8'h01}}, {16{8'h80}}, "R1 unsigned");
      drive(3'd0, 2'd0, 1'b1, '0, {16{8'hFF}}, {16{8'hFE}}, {16{8'hFE}}, "R1 signed");
      drive(3'd0, 2'd0, 1'b0, '0, {16{8'hFF}}, {16{8'hFE}}, {16{8'hFE}}, "R1 unsigned odd");
      // R2 rounding mean
      drive(3'd1, 2'd0, 1'b1, '0, {16{8'hFF}}, {16{8'hFE}}, {16{8'hFF}}, "R2 signed");
      drive(3'd1, 2'd0, 1'b0, '0, {16{8'hFF}}, {16{8'hFF}}, {16{8'hFF}}, "R2 unsigned max");
      // R3 absolute difference
      drive(3'd2, 2'd0, 1'b1, '0, {16{8'h80}}, {16{8'h7F}}, {16{8'hFF}}, "R3 signed wrap");
      drive(3'd2, 2'd0, 1'b0, '0, {16{8'h80}}, {16{8'h7F}}, {16{8'h01}}, "R3 unsigned");
      // R4 sum of magnitudes
      drive(3'd3, 2'd0, 1'b1, '0, {16{8'h80}}, {16{8'h00}}, {16{8'h80}}, "R4 most negative");
      drive(3'd3, 2'd0, 1'b1, '0, {16{8'h05}}, {16{8'hFB}}, {16{8'h0A}}, "R4 signed");
      drive(3'd3, 2'd0, 1'b0, '0, {16{8'h05}}, {16{8'hFB}}, {16{8'h0A}}, "R4 mode ignored");
      // R5 / R6 immediate compare, imm = -2
      drive(3'd4, 2'd0, 1'b1, 5'b11110, {16{8'h05}}, '0, {16{8'hFE}}, "R5 signed");
      drive(3'd4, 2'd0, 1'b0, 5'b11110, {16{8'h05}}, '0, {16{8'h05}}, "R5 unsigned");
      drive(3'd5, 2'd0, 1'b1, 5'b11110, {16{8'h05}}, '0, {16{8'h05}}, "R6 signed");
      drive(3'd5, 2'd0, 1'b0, 5'b11110, {16{8'h05}}, '0, {16{8'hFE}}, "R6 unsigned");
      drive(3'd5, 2'd3, 1'b1, 5'b01111, {2{64'hFFFF_FFFF_FFFF_FFF0}}, '0,
            {2{64'h0000_0000_0000_000F}}, "R6 wide");
      // R7 lane isolation at wider widths
      drive(3'd0, 2'd1, 1'b0, '0, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h8000}}, "R7 w16");
      drive(3'd1, 2'd2, 1'b0, '0, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}},
            {4{32'hFFFF_FFFF}}, "R7 w32");
      drive(3'd2, 2'd3, 1'b1, '0, '0, {VW{1'b1}}, {2{64'h1}}, "R7 w64");
      // R8 unused codes
      drive(3'd6, 2'd0, 1'b0, '0, {16{8'h11}}, {16{8'h22}}, '0, "R8 op6");
      drive(3'd7, 2'd3, 1'b1, 5'b10101, {16{8'h11}}, {16{8'h22}}, '0, "R8 op7");

      // R9 back-to-back sweep, every op, width and mode
      lf = 64'h9E37_79B9_7F4A_7C15;
      for (int rep = 0; rep < 3; rep++) begin
         for (int o = 0; o < 8; o++) begin
            for (int w = 0; w < 4; w++) begin
               for (int s = 0; s < 2; s++) begin
                  logic [VW-1:0] ra, rb;
                  for (int q = 0; q < 4; q++) begin
                     lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
                     ra[q*32 +: 32] = lf[31:0];
                     rb[q*32 +: 32] = lf[63:32];
                  end
                  drive_m(3'(o), 2'(w), s[0], lf[IW-1:0], ra, rb,
                          {"R9 ", op_tag(3'(o))});
               end
            end
         end
      end

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule